// File: doc/BRIEF.md
# Register-Mapped Serial Port (8N1)

This block is a serial port that a processor reaches through a small 32-bit register bus. The bus has an address, a write strobe with write data, and a read strobe. Read data is combinational and valid in the same cycle as the read strobe. Software fills a transmit FIFO one byte at a time, and the block sends each byte as an 8N1 frame: a low start bit, eight data bits least significant bit first, and one high stop bit. Incoming frames are oversampled sixteen times per bit. Each one is stored in a receive FIFO together with its error flags, and software pops that FIFO through the same data port.

A baud word sets the bit rate. A divider counts from zero up to the baud word and then flips an internal sample clock, so the 16x sample period is 2*(word+1) system clocks and one serial bit lasts 32*(word+1) clocks. Software picks the word by taking (clk/baud)>>4 and halving it. When that value is even, it also subtracts one. A status register reports whether the transmit FIFO is empty, whether the receive FIFO holds data, and whether a character was lost to a full receive FIFO. A control register holds the enables and the two FIFO flush bits. Parity-enable and loopback bits are kept in it but change nothing.

Top module: `regbus_uart`

## Requirements
- R1: Registers sit at offset 0x00 (control), 0x04 (baud word), 0x08 (FIFO threshold configuration, bits 15:8, two 4-bit thresholds) and 0x10 (status). The data port is at 0x14. Control, baud word and configuration read back what was written. The control flush bits 6 and 7 always read 0.
- R2: With baud word W, every transmitted bit lasts 32*(W+1) system clocks. No sample tick occurs while control bit 23 (baud generator enable) is 0.
- R3: The transmitter sends bytes in FIFO order as 8N1 frames (start 0, data LSB first, stop 1). The line idles high.
- R4: Transmission needs control bits 22 and 23. Reception needs control bits 21 and 23. Without them, the line stays high, queued bytes stay queued, and arriving frames are not stored.
- R5: Status bit 5 is 1 exactly when the transmit FIFO is empty. Status bit 11 is 1 exactly when the receive FIFO holds an entry.
- R6: A read of the data port pops one receive entry. The character is in bits 7:0, the framing error in bit 8, the parity error in bit 9 (always 0) and break in bit 10. A read of an empty FIFO returns 0.
- R7: A frame starts only on a high-to-low change of the sampled line, and only if the line is still low at the 8th sample. A shorter low pulse stores nothing.
- R8: The framing error is set when the stop sample is low. Break is set when all eight data bits and the stop sample are low.
- R9: A character that completes while the receive FIFO is full is dropped and sets status bit 7. The bit stays set until any write to the status register or a receive FIFO flush.
- R10: Writing control with bit 6 set empties the receive FIFO. Writing control with bit 7 set empties the transmit FIFO.
- R11: After reset, the control register is 0, status reads 0x20 and the transmit line is high.
- R12: Control bits 17, 19 (parity enables) and 20 (loopback) are stored but do not change transmitted frames or feed the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRd | input | 1 | Read strobe (pops the receive FIFO at the data port) |
| regRdata | output | 32 | Combinational read data |
| txLine | output | 1 | Serial transmit line |
| rxLine | input | 1 | Serial receive line (asynchronous) |

## Verification
The bench builds the block with FIFO_DEPTH=4 and BAUD_W=16. The shallow FIFO lets five back-to-back frames reach the overrun case and the receive flush of a full FIFO. Most traffic uses baud word 0, so a frame takes only about 320 clocks. One byte is sent with word 2 to confirm the 32*(W+1) bit length against an independent serial decoder. Framing, break, glitch rejection and the enable gating are all reached through the serial line and the register port alone.

// File: rtl/regbus_uart_pkg.sv
package regbus_uart_pkg;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_BAUD = 'h04;
  localparam int OFF_FCFG = 'h08;
  localparam int OFF_STAT = 'h10;
  localparam int OFF_DATA = 'h14;

  localparam int CTL_RXFLUSH = 6;
  localparam int CTL_TXFLUSH = 7;
  localparam int CTL_RXEN    = 21;
  localparam int CTL_TXEN    = 22;
  localparam int CTL_BRGEN   = 23;

  localparam int ST_TXEMPTY = 5;
  localparam int ST_OVR     = 7;
  localparam int ST_RXNE    = 11;

  typedef struct packed {
    logic txOn;
    logic rxOn;
    logic brgOn;
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
    logic ovrClr;
  } uartStrobes_t;

  typedef struct packed {
    logic       brk;
    logic       parErr;
    logic       frmErr;
    logic [7:0] chr;
  } rxEntry_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;
endpackage

// File: rtl/regbus_uart_fifo.sv
module regbus_uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end
endmodule

// File: rtl/regbus_uart_ctrl.sv
module regbus_uart_ctrl import regbus_uart_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  input  logic              regRd,
  output logic [31:0]       regRdata,
  input  logic              txEmpty,
  input  logic              rxNotEmpty,
  input  logic              ovr,
  input  rxEntry_t          rxHead,
  output uartStrobes_t      strb,
  output logic [BAUD_W-1:0] baudWord
);
  localparam logic [31:0] FLUSH_MASK = (32'd1 << CTL_RXFLUSH) | (32'd1 << CTL_TXFLUSH);

  logic [31:0] ctrlReg;
  logic [7:0]  fcfgReg;
  logic selCtrl, selBaud, selFcfg, selStat, selData;

  assign selCtrl = (regAddr == ADDR_W'(OFF_CTRL));
  assign selBaud = (regAddr == ADDR_W'(OFF_BAUD));
  assign selFcfg = (regAddr == ADDR_W'(OFF_FCFG));
  assign selStat = (regAddr == ADDR_W'(OFF_STAT));
  assign selData = (regAddr == ADDR_W'(OFF_DATA));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      baudWord <= '0;
      fcfgReg  <= '0;
    end else if (regWr) begin
      if (selCtrl) ctrlReg  <= regWdata & ~FLUSH_MASK;
      if (selBaud) baudWord <= regWdata[BAUD_W-1:0];
      if (selFcfg) fcfgReg  <= regWdata[15:8];
    end
  end

  always_comb begin
    strb.brgOn   = ctrlReg[CTL_BRGEN];
    strb.txOn    = ctrlReg[CTL_TXEN] && ctrlReg[CTL_BRGEN];
    strb.rxOn    = ctrlReg[CTL_RXEN] && ctrlReg[CTL_BRGEN];
    strb.txPush  = regWr && selData;
    strb.rxPop   = regRd && selData && rxNotEmpty;
    strb.txFlush = regWr && selCtrl && regWdata[CTL_TXFLUSH];
    strb.rxFlush = regWr && selCtrl && regWdata[CTL_RXFLUSH];
    strb.ovrClr  = regWr && selStat;
  end

  always_comb begin
    regRdata = '0;
    if (selCtrl) begin
      regRdata = ctrlReg;
    end else if (selBaud) begin
      regRdata[BAUD_W-1:0] = baudWord;
    end else if (selFcfg) begin
      regRdata[15:8] = fcfgReg;
    end else if (selStat) begin
      regRdata[ST_TXEMPTY] = txEmpty;
      regRdata[ST_OVR]     = ovr;
      regRdata[ST_RXNE]    = rxNotEmpty;
    end else if (selData && rxNotEmpty) begin
      regRdata[10:0] = rxHead;
    end
  end
endmodule

// File: rtl/regbus_uart_dp.sv
module regbus_uart_dp import regbus_uart_pkg::*; #(
  parameter int BAUD_W = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  uartStrobes_t      strb,
  input  logic [BAUD_W-1:0] baudWord,
  input  logic [7:0]        txData,
  input  logic              rxLine,
  output logic              txLine,
  output logic              txEmpty,
  output logic              rxNotEmpty,
  output rxEntry_t          rxHead,
  output logic              ovr,
  output logic              tick16,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              rxFull,
  output logic              rxDrop
);
  // Baud generator: half-period of the 16x sample clock is word+1 clocks
  logic [BAUD_W-1:0] divCnt;
  logic divHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      divHalf <= 1'b0;
    end else if (!strb.brgOn) begin
      divCnt  <= '0;
      divHalf <= 1'b0;
    end else if (divCnt >= baudWord) begin
      divCnt  <= '0;
      divHalf <= ~divHalf;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tick16 = divHalf && (divCnt >= baudWord);

  // Transmit path
  logic [7:0] txHead;
  logic       txFull, txBusy, txLoad;
  logic [3:0] txSub, txIdx;
  logic [9:0] txShift;

  regbus_uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(strb.txPush), .wdata(txData), .pop(txLoad),
    .flush(strb.txFlush), .head(txHead), .full(txFull), .empty(txEmpty), .count(txCount)
  );

  assign txLoad = strb.txOn && !txBusy && !txEmpty && tick16;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txSub   <= '0;
      txIdx   <= '0;
      txShift <= '1;
    end else if (!strb.txOn) begin
      txBusy <= 1'b0;
    end else if (txLoad) begin
      txBusy  <= 1'b1;
      txSub   <= '0;
      txIdx   <= '0;
      txShift <= {1'b1, txHead, 1'b0};
    end else if (txBusy && tick16) begin
      if (txSub == 4'd15) begin
        txSub <= '0;
        if (txIdx == 4'd9) begin
          txBusy <= 1'b0;
        end else begin
          txIdx   <= txIdx + 1'b1;
          txShift <= {1'b1, txShift[9:1]};
        end
      end else begin
        txSub <= txSub + 1'b1;
      end
    end
  end

  assign txLine = !txBusy || txShift[0];

  // Receive path
  logic       rxS1, rxS2, rxPrev, rxDone;
  rxState_t   rxSt;
  logic [3:0] rxSub;
  logic [2:0] rxIdx;
  logic [7:0] rxShift;
  rxEntry_t   rxNew;
  logic [10:0] rxHeadRaw;
  logic       rxEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1 <= 1'b1;
      rxS2 <= 1'b1;
    end else begin
      rxS1 <= rxLine;
      rxS2 <= rxS1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSt    <= RX_IDLE;
      rxSub   <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
      rxPrev  <= 1'b1;
    end else begin
      if (tick16) rxPrev <= rxS2;
      if (!strb.rxOn) begin
        rxSt <= RX_IDLE;
      end else if (tick16) begin
        case (rxSt)
          RX_IDLE: if (rxPrev && !rxS2) begin
            rxSt  <= RX_START;
            rxSub <= 4'd1;
          end
          RX_START: if (rxSub == 4'd7) begin
            rxSt  <= rxS2 ? RX_IDLE : RX_DATA;
            rxSub <= '0;
            rxIdx <= '0;
          end else begin
            rxSub <= rxSub + 1'b1;
          end
          RX_DATA: if (rxSub == 4'd15) begin
            rxSub   <= '0;
            rxShift <= {rxS2, rxShift[7:1]};
            if (rxIdx == 3'd7) rxSt <= RX_STOP;
            else rxIdx <= rxIdx + 1'b1;
          end else begin
            rxSub <= rxSub + 1'b1;
          end
          default: if (rxSub == 4'd15) begin
            rxSt  <= RX_IDLE;
            rxSub <= '0;
          end else begin
            rxSub <= rxSub + 1'b1;
          end
        endcase
      end
    end
  end

  assign rxDone       = strb.rxOn && tick16 && (rxSt == RX_STOP) && (rxSub == 4'd15);
  assign rxNew.chr    = rxShift;
  assign rxNew.frmErr = !rxS2;
  assign rxNew.parErr = 1'b0;
  assign rxNew.brk    = !rxS2 && (rxShift == 8'h00);
  assign rxDrop       = rxDone && rxFull;

  regbus_uart_fifo #(.WIDTH($bits(rxEntry_t)), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(rxDone), .wdata(rxNew), .pop(strb.rxPop),
    .flush(strb.rxFlush), .head(rxHeadRaw), .full(rxFull), .empty(rxEmpty), .count(rxCount)
  );

  assign rxHead     = rxEntry_t'(rxHeadRaw);
  assign rxNotEmpty = !rxEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ovr <= 1'b0;
    else if (strb.rxFlush) ovr <= 1'b0;
    else if (rxDrop)       ovr <= 1'b1;
    else if (strb.ovrClr)  ovr <= 1'b0;
  end
endmodule

// File: rtl/regbus_uart.sv
module regbus_uart import regbus_uart_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int BAUD_W = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  input  logic              regRd,
  output logic [31:0]       regRdata,
  output logic              txLine,
  input  logic              rxLine
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  uartStrobes_t      strb;
  logic [BAUD_W-1:0] baudWord;
  logic              txEmpty, rxNotEmpty, ovr, tick16, rxFull, rxDrop;
  logic [CNT_W-1:0]  txCount, rxCount;
  rxEntry_t          rxHead;

  regbus_uart_ctrl #(.ADDR_W(ADDR_W), .BAUD_W(BAUD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRd(regRd), .regRdata(regRdata), .txEmpty(txEmpty), .rxNotEmpty(rxNotEmpty),
    .ovr(ovr), .rxHead(rxHead), .strb(strb), .baudWord(baudWord)
  );

  regbus_uart_dp #(.BAUD_W(BAUD_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .baudWord(baudWord), .txData(regWdata[7:0]),
    .rxLine(rxLine), .txLine(txLine), .txEmpty(txEmpty), .rxNotEmpty(rxNotEmpty),
    .rxHead(rxHead), .ovr(ovr), .tick16(tick16), .txCount(txCount), .rxCount(rxCount),
    .rxFull(rxFull), .rxDrop(rxDrop)
  );
endmodule

// File: rtl/regbus_uart_chk.sv
module regbus_uart_chk import regbus_uart_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regRd,
  input logic [31:0]       regRdata,
  input logic              txLine,
  input uartStrobes_t      strb,
  input logic              tick16,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount,
  input logic              rxFull,
  input logic              ovr,
  input logic              rxDrop
);
  assert_tx_high_when_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.txOn |=> txLine);

  assert_no_tick_without_brg_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.brgOn |-> !tick16);

  assert_status_txempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_W'(OFF_STAT)) |-> (regRdata[ST_TXEMPTY] == (txCount == '0)));

  assert_txflush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.txFlush |=> (txCount == '0));

  assert_rxflush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxFlush |=> (rxCount == '0 && !ovr));

  assert_ovr_only_when_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovr) |-> $past(rxFull));

  assert_ovr_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ovrClr && !rxDrop) |=> !ovr);
endmodule

bind regbus_uart regbus_uart_chk #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd), .regRdata(regRdata),
  .txLine(txLine), .strb(strb), .tick16(tick16), .txCount(txCount), .rxCount(rxCount),
  .rxFull(rxFull), .ovr(ovr), .rxDrop(rxDrop)
);

// File: tb/regbus_uart_test.sv
`timescale 1ns/1ps
module regbus_uart_test;
  localparam int ADDR_W = 8;
  localparam int BAUD_W = 16;
  localparam int FIFO_DEPTH = 4;
  localparam logic [31:0] CTRL_ON = 32'h00E0_3705;
  localparam logic [31:0] TX_BIT = 32'h0040_0000;
  localparam logic [31:0] RX_BIT = 32'h0020_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic regRd = 1'b0;
  logic [31:0] regRdata;
  logic txLine;
  logic rxDrv = 1'b1;

  int nChecks = 0;
  int nFails = 0;
  int bitPer = 32;
  string txTag = "R3";
  logic [7:0] txExp[$];
  logic [31:0] rxExp[$];

  always #5 clk = ~clk;

  regbus_uart #(.ADDR_W(ADDR_W), .BAUD_W(BAUD_W), .FIFO_DEPTH(FIFO_DEPTH)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRd(regRd), .regRdata(regRdata), .txLine(txLine), .rxLine(rxDrv)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    regAddr = ADDR_W'(addr); regWdata = data; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input int addr, output logic [31:0] data);
    @(negedge clk);
    regAddr = ADDR_W'(addr); regRd = 1'b1;
    #1 data = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic expectReg(input int addr, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    regRead(addr, v);
    check(v == exp, tag, v, exp);
  endtask

  // Driver: queue the expected byte, then write it to the data port
  task automatic txSend(input logic [7:0] ch);
    txExp.push_back(ch);
    regWrite('h14, {24'h0, ch});
  endtask

  task automatic txDrain();
    while (txExp.size() != 0) @(negedge clk);
    repeat (bitPer * 2) @(negedge clk);
  endtask

  task automatic rxSend(input logic [7:0] ch, input logic stopV);
    rxDrv = 1'b0;
    repeat (bitPer) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxDrv = ch[i];
      repeat (bitPer) @(negedge clk);
    end
    rxDrv = stopV;
    repeat (bitPer) @(negedge clk);
    rxDrv = 1'b1;
    repeat (bitPer) @(negedge clk);
  endtask

  task automatic rxPopCheck(input string tag);
    logic [31:0] v, e;
    regRead('h14, v);
    e = (rxExp.size() != 0) ? rxExp.pop_front() : 32'hDEAD;
    check(v == e, tag, v, e);
  endtask

  // Monitor: decode frames on txLine and compare with the queue
  initial begin
    logic prevL;
    logic [7:0] got;
    logic [7:0] e;
    prevL = 1'b1;
    forever begin
      @(negedge clk);
      if (rstN && prevL && !txLine) begin
        repeat (bitPer / 2) @(negedge clk);
        check(txLine == 1'b0, {txTag, " start bit"}, {31'h0, txLine}, 32'h0);
        for (int i = 0; i < 8; i++) begin
          repeat (bitPer) @(negedge clk);
          got[i] = txLine;
        end
        repeat (bitPer) @(negedge clk);
        check(txLine == 1'b1, {txTag, " stop bit"}, {31'h0, txLine}, 32'h1);
        if (txExp.size() == 0) begin
          check(1'b0, "R4 unexpected frame", {24'h0, got}, 32'h0);
        end else begin
          e = txExp.pop_front();
          check(got == e, {txTag, " tx byte"}, {24'h0, got}, {24'h0, e});
        end
        prevL = 1'b1;
      end else begin
        prevL = txLine;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int lows;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(txLine == 1'b1, "R11 txLine idle", {31'h0, txLine}, 32'h1);
    expectReg('h10, 32'h20, "R11 status after reset");
    expectReg('h00, 32'h0, "R11 control after reset");

    // R1 register map and readback
    regWrite('h04, 32'h0);
    regWrite('h08, 32'h0000_4400);
    regWrite('h00, CTRL_ON | 32'hC0);
    expectReg('h00, CTRL_ON, "R1 control readback, flush bits read 0");
    expectReg('h08, 32'h0000_4400, "R1 fifo config readback");
    regWrite('h04, 32'h0000_1234);
    expectReg('h04, 32'h0000_1234, "R1 baud readback");
    regWrite('h04, 32'h0);

    // R3 frames in FIFO order
    txTag = "R3";
    txSend(8'h55); txSend(8'hA3); txSend(8'h00); txSend(8'hFF);
    txDrain();

    // R2 bit length with baud word 2
    txTag = "R2";
    regWrite('h04, 32'h2);
    bitPer = 96;
    txSend(8'h3C);
    txDrain();
    regWrite('h04, 32'h0);
    bitPer = 32;
    txTag = "R3";

    // R4 transmit gated by enable; R5 empty flag
    regWrite('h00, CTRL_ON & ~TX_BIT);
    regWrite('h14, 32'h81);
    lows = 0;
    repeat (400) begin @(negedge clk); if (!txLine) lows++; end
    check(lows == 0, "R4 line high while tx off", lows, 0);
    expectReg('h10, 32'h0, "R5 tx fifo not empty");
    txExp.push_back(8'h81);
    regWrite('h00, CTRL_ON);
    txDrain();
    expectReg('h10, 32'h20, "R5 tx fifo empty after send");

    // R10 transmit flush
    regWrite('h00, CTRL_ON & ~TX_BIT);
    regWrite('h14, 32'h11);
    regWrite('h14, 32'h22);
    regWrite('h00, (CTRL_ON & ~TX_BIT) | 32'h80);
    expectReg('h10, 32'h20, "R10 tx flush empties fifo");
    regWrite('h00, CTRL_ON);
    lows = 0;
    repeat (400) begin @(negedge clk); if (!txLine) lows++; end
    check(lows == 0, "R10 nothing sent after flush", lows, 0);

    // R6 receive format
    expectReg('h14, 32'h0, "R6 empty read returns 0");
    rxSend(8'h3C, 1'b1); rxExp.push_back(32'h03C);
    expectReg('h10, 32'h820, "R5 rx not empty");
    rxPopCheck("R6 rx char");
    expectReg('h10, 32'h20, "R6 read pops entry");

    // R8 framing error and break
    rxSend(8'hA5, 1'b0); rxExp.push_back(32'h1A5);
    rxPopCheck("R8 framing error flag");
    rxSend(8'h00, 1'b0); rxExp.push_back(32'h500);
    rxPopCheck("R8 break flag");

    // R7 glitch rejection
    rxDrv = 1'b0;
    repeat (8) @(negedge clk);
    rxDrv = 1'b1;
    repeat (bitPer * 12) @(negedge clk);
    expectReg('h10, 32'h20, "R7 short pulse stores nothing");

    // R9 overrun
    for (int k = 0; k < 5; k++) begin
      rxSend(8'h10 + 8'(k), 1'b1);
      if (k < FIFO_DEPTH) rxExp.push_back(32'h10 + k);
    end
    expectReg('h10, 32'h8A0, "R9 overrun with full fifo");
    for (int k = 0; k < FIFO_DEPTH; k++) rxPopCheck("R9 kept entries");
    expectReg('h10, 32'hA0, "R9 fifth char dropped, overrun held");
    regWrite('h10, 32'h0);
    expectReg('h10, 32'h20, "R9 status write clears overrun");

    // R10 receive flush
    for (int k = 0; k < 5; k++) rxSend(8'h60 + 8'(k), 1'b1);
    expectReg('h10, 32'h8A0, "R10 rx full before flush");
    regWrite('h00, CTRL_ON | 32'h40);
    expectReg('h10, 32'h20, "R10 rx flush empties fifo and clears overrun");
    expectReg('h00, CTRL_ON, "R1 flush bit not stored");

    // R4 receive gated by enable
    regWrite('h00, CTRL_ON & ~RX_BIT);
    rxSend(8'h77, 1'b1);
    expectReg('h10, 32'h20, "R4 rx off stores nothing");
    regWrite('h00, CTRL_ON);

    // R12 parity and loopback bits have no effect
    regWrite('h00, CTRL_ON | 32'h001A_0000);
    expectReg('h00, CTRL_ON | 32'h001A_0000, "R12 bits stored");
    txTag = "R12";
    txSend(8'h5A);
    txDrain();
    expectReg('h10, 32'h20, "R12 loopback does not feed receiver");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule